// File: doc/BRIEF.md
# Mode-Gated Cycle Counter

This block is a 64-bit cycle counter that advances by one on each clock edge, but only when the current execution context may be counted. The context is given by three inputs: the privilege level (0 to 3), the security state (secure, non-secure or realm), and a flag that says whether level 3 runs the narrow 32-bit execution state. A 32-bit filter register decides which contexts are excluded from counting.

Some filter bits are base bits that apply to a privilege level. Others are qualifier bits tied to one security state. A qualifier bit does not enable counting by itself. It blocks counting when it differs from its base bit. So in the non-secure and realm states, the effective filter is the exclusive-or of the base bit and the qualifier bit.

A simple write port loads the filter register or either half of the counter. A read port returns one of them one cycle later. A global enable can stop counting altogether.

Top module: `cyc_filter_counter`

## Requirements
- R1: The filter register keeps only these bits: bit 31 (P, level 1 filter), bit 30 (U, level 0 filter), bit 29 (NSK, non-secure level 1 qualifier), bit 28 (NSU, non-secure level 0 qualifier), bit 27 (NSH, level 2 allow) and bit 21 (RLU, realm level 0 qualifier). Written values in every other bit are dropped, and those bits always read as zero.
- R2: Reset is synchronous and active high. It clears the filter register and the counter to zero. After reset, every context is counted except privilege level 2.
- R3: On each clock edge where `cnt_en_i` is 1 and no filter rule suppresses the current context, the counter increases by exactly one. When `cnt_en_i` is 0, the counter holds.
- R4: Counting is suppressed when P=1 in two cases: at level 1 in the secure or realm state, and at level 3 when `el3_narrow_i`=1. At level 3 with `el3_narrow_i`=0, counting is never suppressed.
- R5: At level 0 in the secure state, counting is suppressed exactly when U=1.
- R6: At level 1 in the non-secure state, counting is suppressed exactly when NSK differs from P.
- R7: At level 0 in the non-secure state, counting is suppressed exactly when NSU differs from U.
- R8: At level 0 in the realm state, counting is suppressed exactly when RLU differs from U.
- R9: At level 2, counting is suppressed exactly when NSH=0, in every security state.
- R10: The security state is encoded on `sec_i` as 0 = secure, 1 = non-secure, 2 = realm, 3 = treated as secure. NSK and NSU have no effect outside the non-secure state. RLU has no effect outside the realm state.
- R11: When `wr_en_i`=1, `wr_sel_i` selects the target: 0 = filter register, 1 = counter bits 31:0, 2 = counter bits 63:32, 3 = nothing. A counter write replaces the selected half and blocks that cycle's increment. The other half is left unchanged.
- R12: `rd_data_o` returns, one clock after the request, the item selected by `rd_sel_i`: 0 = filter register, 1 = counter low half, 2 = counter high half, 3 = zero. The value returned is the one held before that edge's write or increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| el_i | input | 2 | Current privilege level |
| sec_i | input | 2 | Security state code |
| el3_narrow_i | input | 1 | Level 3 runs the 32-bit execution state |
| cnt_en_i | input | 1 | Global count enable |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 2 | Write target select |
| wr_data_i | input | 32 | Write data |
| rd_sel_i | input | 2 | Read source select |
| rd_data_o | output | 32 | Registered read data |
| count_o | output | 64 | Counter value |

## Verification
The assertions assume that reset is held for at least one edge before any other activity. They also assume that `wr_sel_i` and `rd_sel_i` are stable, known 2-bit codes at every edge.

The stimulus drives every input at the falling edge, so all inputs are valid at the rising edge. It draws every field of the context from the full code space, including security code 3. Writes are kept sparse, so that each filter setting is held for long enough to count across many contexts.

Directed sequences set each base and qualifier bit pair to the matching and the differing case. A free-running reference model checks every cycle.

// File: rtl/cfc_pkg.sv
package cfc_pkg;
  localparam int DATA_W  = 32;
  localparam int BIT_P   = 31;
  localparam int BIT_U   = 30;
  localparam int BIT_NSK = 29;
  localparam int BIT_NSU = 28;
  localparam int BIT_NSH = 27;
  localparam int BIT_RLU = 21;

  localparam logic [DATA_W-1:0] FILT_KEEP =
      (DATA_W'(1) << BIT_P)   | (DATA_W'(1) << BIT_U)   |
      (DATA_W'(1) << BIT_NSK) | (DATA_W'(1) << BIT_NSU) |
      (DATA_W'(1) << BIT_NSH) | (DATA_W'(1) << BIT_RLU);

  typedef enum logic [1:0] {
    SEC_SECURE = 2'd0,
    SEC_NONSEC = 2'd1,
    SEC_REALM  = 2'd2,
    SEC_SPARE  = 2'd3
  } sec_e;

  typedef enum logic [1:0] {
    SEL_FILT = 2'd0,
    SEL_CLO  = 2'd1,
    SEL_CHI  = 2'd2,
    SEL_NONE = 2'd3
  } sel_e;

  typedef struct packed {
    logic p;
    logic u;
    logic nsk;
    logic nsu;
    logic nsh;
    logic rlu;
  } filt_t;
endpackage

// File: rtl/cfc_filter_reg.sv
module cfc_filter_reg
  import cfc_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] image,
  output filt_t         fields
);
  logic [DW-1:0] held_q;

  always_ff @(posedge clk) begin
    if (rst)     held_q <= '0;
    else if (we) held_q <= wdata & FILT_KEEP;
  end

  assign image  = held_q;
  assign fields = '{p:   held_q[BIT_P],   u:   held_q[BIT_U],
                    nsk: held_q[BIT_NSK], nsu: held_q[BIT_NSU],
                    nsh: held_q[BIT_NSH], rlu: held_q[BIT_RLU]};

  // R1
  filt_load_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(we) && !$past(rst)) |-> (held_q == ($past(wdata) & FILT_KEEP)));
endmodule

// File: rtl/cfc_gate.sv
module cfc_gate
  import cfc_pkg::*;
(
  input  filt_t      f,
  input  logic [1:0] el,
  input  logic [1:0] sec,
  input  logic       el3_narrow,
  output logic       allow
);
  sec_e st;
  logic block;

  assign st = sec_e'(sec);

  always_comb begin
    block = 1'b0;
    unique case (el)
      2'd0: begin
        unique case (st)
          SEC_NONSEC: block = f.u ^ f.nsu;
          SEC_REALM:  block = f.u ^ f.rlu;
          default:    block = f.u;
        endcase
      end
      2'd1:    block = (st == SEC_NONSEC) ? (f.p ^ f.nsk) : f.p;
      2'd2:    block = !f.nsh;
      default: block = el3_narrow & f.p;
    endcase
  end

  assign allow = !block;
endmodule

// File: rtl/cfc_counter.sv
module cfc_counter #(
  parameter int CW = 64,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [DW-1:0] wdata,
  output logic [CW-1:0] value
);
  localparam int HW = CW - DW;

  logic [CW-1:0] cnt_q;

  generate
    if (HW > 0) begin : g_split
      always_ff @(posedge clk) begin
        if (rst)        cnt_q <= '0;
        else if (wr_lo) cnt_q <= {cnt_q[CW-1:DW], wdata};
        else if (wr_hi) cnt_q <= {wdata[HW-1:0], cnt_q[DW-1:0]};
        else if (inc)   cnt_q <= cnt_q + CW'(1);
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst)        cnt_q <= '0;
        else if (wr_lo) cnt_q <= wdata[CW-1:0];
        else if (inc)   cnt_q <= cnt_q + CW'(1);
      end
    end
  endgenerate

  assign value = cnt_q;

  // R3
  inc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(inc) && !$past(wr_lo) && !$past(wr_hi))
      |-> (cnt_q == $past(cnt_q) + CW'(1)));
  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(inc) && !$past(wr_lo) && !$past(wr_hi))
      |-> $stable(cnt_q));
  // R11
  wr_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_lo)) |-> (cnt_q[DW-1:0] == $past(wdata)));
endmodule

// File: rtl/cyc_filter_counter.sv
module cyc_filter_counter
  import cfc_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int DW    = DATA_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       el_i,
  input  logic [1:0]       sec_i,
  input  logic             el3_narrow_i,
  input  logic             cnt_en_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic [1:0]       rd_sel_i,
  output logic [DW-1:0]    rd_data_o,
  output logic [CNT_W-1:0] count_o
);
  localparam int HI_W = CNT_W - DW;

  sel_e          wsel, rsel;
  filt_t         fl;
  logic [DW-1:0] filt_img;
  logic          allow;
  logic          wr_filt, wr_lo, wr_hi;
  logic [DW-1:0] rd_next;

  assign wsel    = sel_e'(wr_sel_i);
  assign rsel    = sel_e'(rd_sel_i);
  assign wr_filt = wr_en_i && (wsel == SEL_FILT);
  assign wr_lo   = wr_en_i && (wsel == SEL_CLO);
  assign wr_hi   = wr_en_i && (wsel == SEL_CHI);

  cfc_filter_reg #(.DW(DW)) u_filt (
    .clk(clk), .rst(rst), .we(wr_filt), .wdata(wr_data_i),
    .image(filt_img), .fields(fl)
  );

  cfc_gate u_gate (
    .f(fl), .el(el_i), .sec(sec_i), .el3_narrow(el3_narrow_i), .allow(allow)
  );

  cfc_counter #(.CW(CNT_W), .DW(DW)) u_cnt (
    .clk(clk), .rst(rst), .inc(cnt_en_i && allow),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wdata(wr_data_i), .value(count_o)
  );

  always_comb begin
    unique case (rsel)
      SEL_FILT: rd_next = filt_img;
      SEL_CLO:  rd_next = count_o[DW-1:0];
      SEL_CHI:  rd_next = DW'(count_o[CNT_W-1:CNT_W-HI_W]);
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data_o <= '0;
    else     rd_data_o <= rd_next;
  end

  // R1
  rd_rsv_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(rd_sel_i) == 2'd0))
      |-> ((rd_data_o & ~FILT_KEEP) == '0));
  // R9
  el2_block_chk: assert property (@(posedge clk) disable iff (rst)
    (el_i == 2'd2 && !fl.nsh && !wr_lo && !wr_hi) |=> $stable(count_o));
  // R3
  en_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!cnt_en_i && !wr_lo && !wr_hi) |=> $stable(count_o));
endmodule

// File: tb/cyc_filter_counter_tb_top.sv
module cyc_filter_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  el_i = '0, sec_i = '0, wr_sel_i = 2'd3, rd_sel_i = 2'd3;
  logic        el3_narrow_i = 1'b0, cnt_en_i = 1'b0, wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic [63:0] count_o;

  int total = 0, bad = 0;
  bit done = 0;
  logic [63:0] m_cnt;
  logic [31:0] m_filt;

  always #10 clk = ~clk;

  cyc_filter_counter dut_i (
    .clk(clk), .rst(rst), .el_i(el_i), .sec_i(sec_i),
    .el3_narrow_i(el3_narrow_i), .cnt_en_i(cnt_en_i), .wr_en_i(wr_en_i),
    .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .rd_sel_i(rd_sel_i),
    .rd_data_o(rd_data_o), .count_o(count_o)
  );

  function automatic bit m_allow(input logic [31:0] f, input logic [1:0] el,
                                 input logic [1:0] sec, input logic nar);
    bit p = f[31], u = f[30], nsk = f[29], nsu = f[28], nsh = f[27], rlu = f[21];
    case (el)
      2'd0: return (sec == 2'd1) ? (u == nsu) : (sec == 2'd2) ? (u == rlu) : !u;
      2'd1: return (sec == 2'd1) ? (p == nsk) : !p;
      2'd2: return nsh;
      default: return !(nar && p);
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: inputs set at falling edge, results checked at next falling edge
  task automatic cyc(input string tag, input logic [1:0] el, input logic [1:0] sec,
                     input logic nar, input logic en, input logic we,
                     input logic [1:0] ws, input logic [31:0] wd, input logic [1:0] rs);
    logic [63:0] n_cnt;
    logic [31:0] n_filt, e_rd;
    el_i = el; sec_i = sec; el3_narrow_i = nar; cnt_en_i = en;
    wr_en_i = we; wr_sel_i = ws; wr_data_i = wd; rd_sel_i = rs;
    e_rd = (rs == 2'd0) ? m_filt : (rs == 2'd1) ? m_cnt[31:0] :
           (rs == 2'd2) ? m_cnt[63:32] : 32'd0;
    n_cnt = m_cnt; n_filt = m_filt;
    if (we && ws == 2'd0)      n_filt = wd & 32'hF820_0000;
    if (we && ws == 2'd1)      n_cnt[31:0] = wd;
    else if (we && ws == 2'd2) n_cnt[63:32] = wd;
    else if (en && m_allow(m_filt, el, sec, nar)) n_cnt = m_cnt + 64'd1;
    @(posedge clk);
    @(negedge clk);
    m_cnt = n_cnt; m_filt = n_filt;
    chk(tag, count_o, m_cnt);
    chk({tag, " R12 read"}, {32'd0, rd_data_o}, {32'd0, e_rd});
  endtask

  task automatic setf(input logic [31:0] v);
    cyc("R1 filter write", 2'd0, 2'd0, 1'b0, 1'b0, 1'b1, 2'd0, v, 2'd3);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd5150);
    m_cnt = '0; m_filt = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R2 reset state
    chk("R2 count after reset", count_o, 64'd0);
    cyc("R2 filter reset read", 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd3, 0, 2'd0);
    chk("R2 filter is zero", {32'd0, rd_data_o}, 64'd0);
    for (int e = 0; e < 4; e++)
      cyc("R2 unfiltered after reset", e[1:0], 2'd1, 1'b1, 1'b1, 1'b0, 2'd3, 0, 2'd3);
    // R1 reserved bits dropped
    setf(32'hFFFF_FFFF);
    cyc("R1 mask read", 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd3, 0, 2'd0);
    chk("R1 kept bits", {32'd0, rd_data_o}, 64'h0000_0000_F820_0000);
    // R4 P bit
    setf(32'h8800_0000);
    cyc("R4 secure EL1 blocked", 2'd1, 2'd0, 1'b0, 1'b1, 1'b0, 2'd3, 0, 2'd3);
    cyc("R4 realm EL1 blocked", 2'd1, 2'd2, 1'b0, 1'b1, 1'b0, 2'd3, 0, 2'd3);
    cyc("R4 EL3 narrow blocked", 2'd3, 2'd0, 1'b1, 1'b1, 1'b0, 2'd3, 0, 2'd3);
    cyc("R4 EL3 wide counts", 2'd3, 2'd0, 1'b0, 1'b1, 1'b0, 2'd3, 0, 2'd3);
    // R6 NSK vs P
    cyc("R6 NS EL1 P=1 NSK=0 blocked", 2'd1, 2'd1, 1'b0, 1'b1, 1'b0, 2'd3, 0, 2'd3);
    setf(32'hA800_0000);
    cyc("R6 NS EL1 P=1 NSK=1 counts", 2'd1, 2'd1, 1'b0, 1'b1, 1'b0, 2'd3, 0, 2'd3);
    setf(32'h2800_0000);
    cyc("R6 NS EL1 P=0 NSK=1 blocked", 2'd1, 2'd1, 1'b0, 1'b1, 1'b0, 2'd3, 0, 2'd3);
    cyc("R10 secure EL1 ignores NSK", 2'd1, 2'd0, 1'b0, 1'b1, 1'b0, 2'd3, 0, 2'd3);
    cyc("R10 spare code EL1 ignores NSK", 2'd1, 2'd3, 1'b0, 1'b1, 1'b0, 2'd3, 0, 2'd3);
    // R5 R7 R8 U with qualifiers
    setf(32'h4800_0000);
    cyc("R5 secure EL0 U=1 blocked", 2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 2'd3, 0, 2'd3);
    cyc("R7 NS EL0 U=1 NSU=0 blocked", 2'd0, 2'd1, 1'b0, 1'b1, 1'b0, 2'd3, 0, 2'd3);
    cyc("R8 realm EL0 U=1 RLU=0 blocked", 2'd0, 2'd2, 1'b0, 1'b1, 1'b0, 2'd3, 0, 2'd3);
    setf(32'h5820_0000);
    cyc("R7 NS EL0 U=1 NSU=1 counts", 2'd0, 2'd1, 1'b0, 1'b1, 1'b0, 2'd3, 0, 2'd3);
    cyc("R8 realm EL0 U=1 RLU=1 counts", 2'd0, 2'd2, 1'b0, 1'b1, 1'b0, 2'd3, 0, 2'd3);
    cyc("R10 secure EL0 ignores NSU RLU", 2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 2'd3, 0, 2'd3);
    setf(32'h1800_0000);
    cyc("R7 NS EL0 U=0 NSU=1 blocked", 2'd0, 2'd1, 1'b0, 1'b1, 1'b0, 2'd3, 0, 2'd3);
    cyc("R10 realm EL0 ignores NSU", 2'd0, 2'd2, 1'b0, 1'b1, 1'b0, 2'd3, 0, 2'd3);
    setf(32'h0820_0000);
    cyc("R8 realm EL0 U=0 RLU=1 blocked", 2'd0, 2'd2, 1'b0, 1'b1, 1'b0, 2'd3, 0, 2'd3);
    cyc("R10 NS EL0 ignores RLU", 2'd0, 2'd1, 1'b0, 1'b1, 1'b0, 2'd3, 0, 2'd3);
    // R9 EL2
    for (int s = 0; s < 4; s++)
      cyc("R9 EL2 NSH=1 counts", 2'd2, s[1:0], 1'b0, 1'b1, 1'b0, 2'd3, 0, 2'd3);
    setf(32'h0000_0000);
    for (int s = 0; s < 4; s++)
      cyc("R9 EL2 NSH=0 blocked", 2'd2, s[1:0], 1'b0, 1'b1, 1'b0, 2'd3, 0, 2'd3);
    // R3 enable off
    cyc("R3 enable low holds", 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd3, 0, 2'd3);
    // R11 counter writes beat increments; wraparound across halves
    cyc("R11 write low", 2'd0, 2'd0, 1'b0, 1'b1, 1'b1, 2'd1, 32'hFFFF_FFFE, 2'd1);
    cyc("R11 write high", 2'd0, 2'd0, 1'b0, 1'b1, 1'b1, 2'd2, 32'h0000_00AB, 2'd2);
    cyc("R3 count carry", 2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 2'd3, 0, 2'd1);
    cyc("R3 count carry", 2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 2'd3, 0, 2'd2);
    chk("R3 carry into high half", count_o, 64'h0000_00AC_0000_0000);
    cyc("R12 read high", 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd3, 0, 2'd2);
    cyc("R11 write sel 3 ignored", 2'd0, 2'd0, 1'b0, 1'b0, 1'b1, 2'd3, 32'h1234_5678, 2'd3);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r = $urandom;
      logic we = ($urandom % 12) == 0;
      cyc("R3 random model", r[1:0], r[3:2], r[4], (r[7:5] != 0), we, r[9:8],
          $urandom, r[11:10]);
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule